// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ready/Busy Flow Control

This block turns an asynchronous serial line into bytes. It has its own bit-rate generator. A two-position prescaler picks the count source: the system clock itself, or the system clock divided by eight. An 8-bit reload value n then divides that source by (n+1), which gives sixteen sub-bit ticks per bit period. Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. There is no parity bit.

A falling edge on the synchronized serial input starts a frame. Every bit is sampled on the eighth of its sixteen ticks. The start bit is checked at mid-bit, so a short low pulse is rejected as noise. When the stop bit has been sampled, the assembled byte moves from the shift register into a holding buffer. At the same moment a buffer-full flag and a sticky interrupt request are raised. The shift register is then free to take the next frame while the previous byte waits to be read.

A flow-control output tells the far transmitter whether it may send. It is driven high (not ready) in three cases: while a frame is being received, while an unread byte sits in the buffer, or while reception is disabled. A framing-error flag and an overrun flag describe the most recent transfer.

Top module: `uart_rx_fc`

## Requirements
- R1: One bit period lasts 16×(n+1) count-source cycles, where n is `brg_div_i`. The count source is `clk` when `clk_sel_i`=0 and `clk`/8 when `clk_sel_i`=1.
- R2: While `rx_en_i`=1 and the receiver is idle, a high-to-low transition of `rxd_i` starts a frame. `rxd_i` passes through a two-flop synchronizer before edge detection.
- R3: The start bit is sampled on its 8th sub-bit tick. If it reads high, the receiver returns to idle and nothing is stored.
- R4: The eight data bits are taken least significant bit first. After the stop bit is sampled, the byte appears on `rx_data_o` and `rx_full_o` becomes 1.
- R5: `irq_o` becomes 1 on every transfer into the buffer and stays 1 until `irq_clr_i` is pulsed. A transfer in the same cycle as the clear wins.
- R6: A `rd_i` pulse clears `rx_full_o` and leaves `rx_data_o` unchanged.
- R7: `rts_o` is 1 while a frame is in progress, while `rx_full_o`=1, and while `rx_en_i`=0. Otherwise it is 0.
- R8: A stop bit sampled low sets `ferr_o`=1 for that transfer, and the byte is still stored. A good stop bit sets `ferr_o`=0.
- R9: A transfer that happens while `rx_full_o`=1 (and no read in the same cycle) sets `ovr_o`=1, and the new byte overwrites the buffer. Any other transfer sets `ovr_o`=0.
- R10: With `rx_en_i`=0, falling edges are ignored. Dropping `rx_en_i` during a frame abandons that frame without a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| brg_div_i | input | 8 | Bit-rate reload value n |
| clk_sel_i | input | 1 | Count source: 0 = clk, 1 = clk/8 |
| rx_en_i | input | 1 | Receive enable |
| rd_i | input | 1 | Buffer read strobe |
| irq_clr_i | input | 1 | Interrupt request clear / acknowledge |
| rx_data_o | output | 8 | Receive buffer |
| rx_full_o | output | 1 | Receive-complete flag |
| irq_o | output | 1 | Interrupt request flag |
| ferr_o | output | 1 | Framing error of the last transfer |
| ovr_o | output | 1 | Overrun on the last transfer |
| rts_o | output | 1 | Flow control, 1 = not ready |

## Verification
The hardest cases to reach are those that depend on where the receiver sits inside a frame: a flow-control check taken in the middle of a frame, an enable dropped partway through one, and a low pulse shorter than half a bit. The bench drives the serial line bit by bit from a period it computes from the divisor and prescaler. It forks a watcher that samples `rts_o` a few bits into the frame. It drops the enable after three bit periods, and it drives a four-cycle low pulse against a 64-cycle bit. Overrun is reached by sending two frames back to back with no read between them.

// File: rtl/uart_rx_fc_pkg.sv
package uart_rx_fc_pkg;

    // Sub-bit ticks per bit and the tick index that samples the line
    localparam int OVS        = 16;
    localparam int SAMPLE_IDX = 7;
    // Slow count source divides the clock by this amount
    localparam int PRESC      = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    // Result of a completed frame, handed from framer to buffer
    typedef struct packed {
        logic       load;
        logic       stop_ok;
        logic [7:0] data;
    } rx_frame_t;

    function automatic logic [7:0] shift_in_lsb_first(input logic [7:0] cur,
                                                      input logic bit_in);
        return {bit_in, cur[7:1]};
    endfunction

endpackage

// File: rtl/uart_rx_fc_brg.sv
module uart_rx_fc_brg #(
    parameter int DIV_W = 8,
    parameter int PRE   = uart_rx_fc_pkg::PRESC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic             sel_slow_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRE - 1);

    logic [PW-1:0]    pcnt;
    logic [DIV_W-1:0] dcnt;
    logic             src_en;

    // Prescaler: enables every PRE cycles when the slow source is selected
    always_ff @(posedge clk) begin
        if (rst || restart_i) pcnt <= '0;
        else if (pcnt == PRE_LAST) pcnt <= '0;
        else pcnt <= pcnt + 1'b1;
    end

    assign src_en = sel_slow_i ? (pcnt == PRE_LAST) : 1'b1;

    // Reload divider: one tick per (n+1) source enables
    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt   <= '0;
            tick_o <= 1'b0;
        end else if (restart_i) begin
            dcnt   <= div_i;
            tick_o <= 1'b0;
        end else if (src_en) begin
            if (dcnt == '0) begin
                dcnt   <= div_i;
                tick_o <= 1'b1;
            end else begin
                dcnt   <= dcnt - 1'b1;
                tick_o <= 1'b0;
            end
        end else begin
            tick_o <= 1'b0;
        end
    end

    // R1: with the fast source a count below the reload never ticks next cycle
    p_div_count_r1: assert property (@(posedge clk) disable iff (rst)
        (!restart_i && !sel_slow_i && dcnt != '0) |=> !tick_o);

endmodule

// File: rtl/uart_rx_fc_sync.sv
module uart_rx_fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd_i,
    output logic rxd_s_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Metastability chain, reset to the idle (high) level
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], rxd_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign rxd_s_o = chain[STAGES-1];
    assign fall_o  = prev & ~chain[STAGES-1];

endmodule

// File: rtl/uart_rx_fc_frame.sv
module uart_rx_fc_frame
    import uart_rx_fc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  logic      rxd_s_i,
    input  logic      fall_i,
    input  logic      tick_i,
    output logic      restart_o,
    output logic      busy_o,
    output rx_frame_t frame_o
);
    localparam int SUB_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [SUB_W-1:0] SUB_SAMPLE = SUB_W'(SAMPLE_IDX);
    localparam logic [SUB_W-1:0] SUB_LAST   = SUB_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(DATA_W - 1);

    rx_state_e         state;
    logic [SUB_W-1:0]  sub;
    logic [BIT_W-1:0]  bit_idx;
    logic [7:0]        shreg;
    logic              sample_now;
    logic              bit_end;

    assign restart_o  = (state == ST_IDLE) && fall_i && en_i;
    assign sample_now = tick_i && (sub == SUB_SAMPLE);
    assign bit_end    = tick_i && (sub == SUB_LAST);
    assign busy_o     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            sub           <= '0;
            bit_idx       <= '0;
            shreg         <= '0;
            frame_o       <= '0;
        end else begin
            frame_o.load <= 1'b0;
            if (!en_i) begin
                state <= ST_IDLE;
                sub   <= '0;
            end else begin
                if (tick_i) sub <= sub + 1'b1;
                unique case (state)
                    ST_IDLE: begin
                        if (fall_i) begin
                            state   <= ST_START;
                            sub     <= '0;
                            bit_idx <= '0;
                        end
                    end
                    ST_START: begin
                        if (sample_now && rxd_s_i) state <= ST_IDLE;
                        else if (bit_end)          state <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (sample_now) shreg <= shift_in_lsb_first(shreg, rxd_s_i);
                        if (bit_end) begin
                            if (bit_idx == BIT_LAST) state <= ST_STOP;
                            else bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (sample_now) begin
                            frame_o.load    <= 1'b1;
                            frame_o.stop_ok <= rxd_s_i;
                            frame_o.data    <= shreg;
                            state           <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R10: a disabled receiver is idle on the following cycle
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (state == ST_IDLE));

    // R2: a frame only begins after an enabled falling edge
    p_start_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && $past(state) == ST_IDLE) |-> $past(fall_i && en_i));

    // R3: a start bit read high never reaches the data phase
    p_glitch_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && sample_now && rxd_s_i) |=> (state == ST_IDLE));

endmodule

// File: rtl/uart_rx_fc_buf.sv
module uart_rx_fc_buf
    import uart_rx_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_frame_t  frame_i,
    input  logic       rd_i,
    input  logic       irq_clr_i,
    output logic [7:0] data_o,
    output logic       full_o,
    output logic       irq_o,
    output logic       ferr_o,
    output logic       ovr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            full_o <= 1'b0;
            irq_o  <= 1'b0;
            ferr_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            if (frame_i.load) begin
                data_o <= frame_i.data;
                full_o <= 1'b1;
                irq_o  <= 1'b1;
                ferr_o <= ~frame_i.stop_ok;
                ovr_o  <= full_o & ~rd_i;
            end else begin
                if (rd_i)      full_o <= 1'b0;
                if (irq_clr_i) irq_o  <= 1'b0;
            end
        end
    end

    // R4/R5: a transfer leaves the buffer full and the request raised
    p_load_flags_r5: assert property (@(posedge clk) disable iff (rst)
        frame_i.load |=> (full_o && irq_o));

    // R6: a read with no transfer empties the buffer and keeps the data
    p_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !frame_i.load) |=> (!full_o && $stable(data_o)));

    // R8: a bad stop bit is flagged on its transfer
    p_ferr_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_i.load && !frame_i.stop_ok) |=> ferr_o);

    // R9: a transfer onto an unread byte flags overrun
    p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_i.load && full_o && !rd_i) |=> ovr_o);

endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
    import uart_rx_fc_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd_i,
    input  logic [DIV_W-1:0] brg_div_i,
    input  logic             clk_sel_i,
    input  logic             rx_en_i,
    input  logic             rd_i,
    input  logic             irq_clr_i,
    output logic [7:0]       rx_data_o,
    output logic             rx_full_o,
    output logic             irq_o,
    output logic             ferr_o,
    output logic             ovr_o,
    output logic             rts_o
);
    logic      rxd_s;
    logic      fall;
    logic      tick;
    logic      restart;
    logic      busy;
    rx_frame_t frame;

    uart_rx_fc_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .rxd_i   (rxd_i),
        .rxd_s_o (rxd_s),
        .fall_o  (fall)
    );

    uart_rx_fc_brg #(.DIV_W(DIV_W), .PRE(PRESC)) u_brg (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (restart),
        .sel_slow_i (clk_sel_i),
        .div_i      (brg_div_i),
        .tick_o     (tick)
    );

    uart_rx_fc_frame #(.DATA_W(8)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .en_i      (rx_en_i),
        .rxd_s_i   (rxd_s),
        .fall_i    (fall),
        .tick_i    (tick),
        .restart_o (restart),
        .busy_o    (busy),
        .frame_o   (frame)
    );

    uart_rx_fc_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .frame_i   (frame),
        .rd_i      (rd_i),
        .irq_clr_i (irq_clr_i),
        .data_o    (rx_data_o),
        .full_o    (rx_full_o),
        .irq_o     (irq_o),
        .ferr_o    (ferr_o),
        .ovr_o     (ovr_o)
    );

    // Not ready while receiving, while holding an unread byte, or while disabled
    assign rts_o = busy | rx_full_o | ~rx_en_i;

    // R7: a byte never completes while the receiver is flagged ready
    p_rts_ready_r7: assert property (@(posedge clk) disable iff (rst)
        frame.load |-> $past(rts_o));

endmodule

// File: tb/uart_rx_fc_tb_top.sv
module uart_rx_fc_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       rxd;
    logic [7:0] div;
    logic       sel;
    logic       en;
    logic       rd;
    logic       iclr;
    logic [7:0] data;
    logic       full, irq, ferr, ovr, rts;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_rx_fc dut_i (
        .clk(clk), .rst(rst), .rxd_i(rxd), .brg_div_i(div), .clk_sel_i(sel),
        .rx_en_i(en), .rd_i(rd), .irq_clr_i(iclr), .rx_data_o(data),
        .rx_full_o(full), .irq_o(irq), .ferr_o(ferr), .ovr_o(ovr), .rts_o(rts)
    );

    typedef struct packed {
        logic       slow;
        logic [7:0] n;
        logic [7:0] byte_v;
        logic       stop;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd3, 8'hA5, 1'b1},
        '{1'b0, 8'd0, 8'h3C, 1'b1},
        '{1'b0, 8'd5, 8'h81, 1'b1},
        '{1'b1, 8'd1, 8'h7E, 1'b1},
        '{1'b0, 8'd3, 8'hFF, 1'b0},
        '{1'b0, 8'd2, 8'h00, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic int bit_clks(input logic slow, input logic [7:0] n);
        return 16 * (int'(n) + 1) * (slow ? 8 : 1);
    endfunction

    task automatic send_frame(input logic [7:0] b, input logic stop, input int bc);
        @(negedge clk) rxd = 1'b0;
        wait_clks(bc);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_clks(bc);
        end
        rxd = stop;
        wait_clks(bc);
        rxd = 1'b1;
        wait_clks(4);
    endtask

    task automatic pulse_rd_clr(input logic r, input logic c);
        @(negedge clk);
        rd = r; iclr = c;
        @(negedge clk);
        rd = 1'b0; iclr = 1'b0;
        wait_clks(1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int bc;
        rst = 1'b1; rxd = 1'b1; div = 8'd3; sel = 1'b0; en = 1'b0; rd = 1'b0; iclr = 1'b0;
        wait_clks(4);
        rst = 1'b0;
        wait_clks(2);
        check("R7 reset rts while disabled", rts, 1);
        check("R4 reset full", full, 0);
        check("R5 reset irq", irq, 0);
        check("R4 reset data", data, 0);
        en = 1'b1;
        wait_clks(2);
        check("R7 ready when enabled and idle", rts, 0);

        // Table of rates, data patterns and stop-bit levels
        for (int v = 0; v < NV; v++) begin
            sel = VECS[v].slow; div = VECS[v].n;
            bc = bit_clks(VECS[v].slow, VECS[v].n);
            send_frame(VECS[v].byte_v, VECS[v].stop, bc);
            check("R1 R4 byte received", data, VECS[v].byte_v);
            check("R4 full set", full, 1);
            check("R5 irq set", irq, 1);
            check("R8 framing flag", ferr, VECS[v].stop ? 0 : 1);
            check("R9 no overrun", ovr, 0);
            check("R7 rts high while full", rts, 1);
            pulse_rd_clr(1'b1, 1'b1);
            check("R6 full cleared by read", full, 0);
            check("R6 data kept after read", data, VECS[v].byte_v);
            check("R5 irq cleared", irq, 0);
            check("R7 rts low after read", rts, 0);
        end

        sel = 1'b0; div = 8'd3; bc = bit_clks(1'b0, 8'd3);

        // R7: mid-frame flow control
        fork
            send_frame(8'h5A, 1'b1, bc);
            begin
                wait_clks(3 * bc);
                check("R7 rts high during frame", rts, 1);
            end
        join
        // R5: irq held until cleared, independent of read
        pulse_rd_clr(1'b1, 1'b0);
        check("R5 irq held after read only", irq, 1);
        check("R7 rts low with irq still pending", rts, 0);
        pulse_rd_clr(1'b0, 1'b1);
        check("R5 irq cleared by ack", irq, 0);

        // R9: overrun, newer byte overwrites
        send_frame(8'h11, 1'b1, bc);
        send_frame(8'h22, 1'b1, bc);
        check("R9 overrun flagged", ovr, 1);
        check("R9 newer byte kept", data, 8'h22);
        check("R9 full still set", full, 1);
        pulse_rd_clr(1'b1, 1'b1);

        // R3: a short low pulse is rejected
        @(negedge clk) rxd = 1'b0;
        wait_clks(4);
        rxd = 1'b1;
        wait_clks(12 * bc);
        check("R3 glitch stores nothing", full, 0);
        check("R3 glitch leaves data", data, 8'h22);
        check("R3 rts ready after glitch", rts, 0);

        // R10: disabled receiver ignores a whole frame
        en = 1'b0;
        send_frame(8'h99, 1'b1, bc);
        check("R10 disabled no transfer", full, 0);
        check("R7 R10 rts high while disabled", rts, 1);
        en = 1'b1;
        wait_clks(2);

        // R10: enable dropped mid-frame abandons it
        fork
            send_frame(8'hC3, 1'b1, bc);
            begin
                wait_clks(3 * bc);
                en = 1'b0;
            end
        join
        en = 1'b1;
        wait_clks(4);
        check("R10 aborted frame not stored", full, 0);
        check("R10 aborted frame data", data, 8'h22);

        // Receiver recovers; overrun clears on a clean transfer
        send_frame(8'h6B, 1'b1, bc);
        check("R4 byte after abort", data, 8'h6B);
        check("R9 overrun cleared on clean transfer", ovr, 0);
        check("R2 R4 full after abort", full, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule